// File: doc/BRIEF.md
# Completion Counter with Interrupt Coalescing

This block tracks finished output work for one channel and decides when the host should be interrupted. Each completion event on the event input adds either one or the event's byte count to a 32-bit running count. The counting mode is chosen by a control bit. Software returns credit by writing an amount to an acknowledge register, and that amount is subtracted from the count.

Two sticky summary flags drive the interrupt. The first is a level flag, raised when the count reaches a programmed threshold. The second is an age flag, raised once the count has stayed non-zero for longer than a programmed number of clocks. Each flag is gated by its own enable before it reaches the interrupt output. This lets the host take one interrupt for a batch of completions and still bounds how long a lone completion can wait.

Registers are written through a simple word-wide write port with byte enables. Actions that a write triggers (acknowledge, control update, flag clear) happen only when byte lane 0 is enabled.

Top module: `evt_coalesce`

## Requirements
- R1: After reset, count_o is 0, both flags and irq_o are 0, the threshold register is all ones, the timeout register is 0, and all control bits are 0.
- R2: With control bit 0 (byte mode) clear, each cycle with evt_valid_i high adds 1 to count_o on the next cycle.
- R3: With control bit 0 set, each event adds evt_bytes_i to count_o on the next cycle.
- R4: A write to address 3 (acknowledge) with wr_be_i[0] set subtracts the full wr_data_i from the count. The same write with wr_be_i[0] clear leaves count_o unchanged.
- R5: When an event and an acknowledge arrive in the same cycle, both are applied. If the subtraction would go below zero, the count stops at 0. If the addition would exceed the maximum, the count stops at all ones.
- R6: sum_count_o becomes 1 on the clock edge after a cycle in which count_o is greater than or equal to the threshold (address 1).
- R7: With timeout T (address 2) non-zero, sum_time_o becomes 1 at the (T+1)-th clock edge after count_o became non-zero, provided count_o stays non-zero throughout.
- R8: The age timer restarts from zero each time count_o returns to zero, so a new non-zero period again needs T+1 edges.
- R9: With the timeout register at 0, sum_time_o never sets.
- R10: A write to address 4 with wr_be_i[0] set clears sum_count_o where data bit 0 is 1 and clears sum_time_o where data bit 1 is 1. If the set condition holds in the same cycle, the set wins.
- R11: irq_o equals (sum_count_o AND control bit 1) OR (sum_time_o AND control bit 2). The control register is at address 0, is written only when wr_be_i[0] is set, and takes effect in the cycle after the write.
- R12: Writes to the threshold and timeout registers update only the byte lanes whose wr_be_i bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 ctrl, 1 threshold, 2 timeout, 3 acknowledge, 4 flag clear |
| wr_data_i | input | 32 | Write data |
| wr_be_i | input | 4 | Byte enables of the write |
| evt_valid_i | input | 1 | One completion event this cycle |
| evt_bytes_i | input | 16 | Byte count of the event |
| count_o | output | 32 | Current completion count |
| sum_count_o | output | 1 | Sticky threshold flag |
| sum_time_o | output | 1 | Sticky age flag |
| irq_o | output | 1 | Enabled interrupt request |

## Verification
A wrong count shows on count_o one cycle after the event or acknowledge that caused it. The same error also shifts the threshold flag one cycle later. A timer that fails to restart or stop makes sum_time_o rise early or never. This is visible within T+1 cycles of the count leaving zero, so the bench places exact-edge checks on both sides of that instant. A lost or misprioritised flag clear shows on the flag outputs in the cycle after the clear write.

// File: rtl/evt_coal_pkg.sv
package evt_coal_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_LEVEL   = 3'd1,
    REG_TIMEOUT = 3'd2,
    REG_ACK     = 3'd3,
    REG_STATUS  = 3'd4
  } reg_addr_e;

  // bit 0 byte_mode, bit 1 en_count, bit 2 en_time
  typedef struct packed {
    logic en_time;
    logic en_count;
    logic byte_mode;
  } ctrl_t;

  localparam int STAT_CNT_BIT  = 0;
  localparam int STAT_TIME_BIT = 1;
endpackage

// File: rtl/coal_regs.sv
module coal_regs
  import evt_coal_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [CNT_W/8-1:0] wr_be_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  level_o,
  output logic [CNT_W-1:0]  timeout_o,
  output logic              ack_fire_o,
  output logic [CNT_W-1:0]  ack_val_o,
  output logic              clr_cnt_o,
  output logic              clr_time_o
);
  localparam int NB = CNT_W / 8;

  logic sel_ctrl, sel_level, sel_tout, sel_ack, sel_stat;
  ctrl_t ctrl_q;
  logic [CNT_W-1:0] level_q, tout_q;

  assign sel_ctrl  = wr_en_i && (wr_addr_i == REG_CTRL);
  assign sel_level = wr_en_i && (wr_addr_i == REG_LEVEL);
  assign sel_tout  = wr_en_i && (wr_addr_i == REG_TIMEOUT);
  assign sel_ack   = wr_en_i && (wr_addr_i == REG_ACK);
  assign sel_stat  = wr_en_i && (wr_addr_i == REG_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ctrl_q <= '0;
    else if (sel_ctrl && wr_be_i[0]) ctrl_q <= ctrl_t'(wr_data_i[2:0]);
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        level_q[8*b +: 8] <= 8'hff;
        tout_q[8*b +: 8]  <= 8'h00;
      end else begin
        if (sel_level && wr_be_i[b]) level_q[8*b +: 8] <= wr_data_i[8*b +: 8];
        if (sel_tout && wr_be_i[b])  tout_q[8*b +: 8]  <= wr_data_i[8*b +: 8];
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign level_o    = level_q;
  assign timeout_o  = tout_q;
  // trigger-type writes act only when the low byte is written
  assign ack_fire_o = sel_ack && wr_be_i[0];
  assign ack_val_o  = wr_data_i;
  assign clr_cnt_o  = sel_stat && wr_be_i[0] && wr_data_i[STAT_CNT_BIT];
  assign clr_time_o = sel_stat && wr_be_i[0] && wr_data_i[STAT_TIME_BIT];
endmodule

// File: rtl/coal_counter.sv
module coal_counter #(
  parameter int CNT_W   = 32,
  parameter int BYTES_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               evt_valid_i,
  input  logic [BYTES_W-1:0] evt_bytes_i,
  input  logic               byte_mode_i,
  input  logic               ack_fire_i,
  input  logic [CNT_W-1:0]   ack_val_i,
  output logic [CNT_W-1:0]   count_o
);
  localparam int EXT_W = CNT_W + 1;
  localparam logic [EXT_W-1:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] inc, sub, with_inc, diff;

  always_comb begin
    inc = '0;
    if (evt_valid_i) inc = byte_mode_i ? EXT_W'(evt_bytes_i) : EXT_W'(1);
    sub      = ack_fire_i ? {1'b0, ack_val_i} : '0;
    with_inc = {1'b0, cnt_q} + inc;
    diff     = with_inc - sub;
    if (with_inc <= sub)     cnt_d = '0;
    else if (diff > MAX_EXT) cnt_d = '1;
    else                     cnt_d = diff[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_nz_i,
  output logic [CNT_W-1:0] timer_o
);
  logic [CNT_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tmr_q <= '0;
    else if (!count_nz_i) tmr_q <= '0;
    else if (tmr_q != '1) tmr_q <= tmr_q + 1'b1;
  end

  assign timer_o = tmr_q;
endmodule

// File: rtl/coal_flags.sv
module coal_flags #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] level_i,
  input  logic [CNT_W-1:0] timer_i,
  input  logic [CNT_W-1:0] timeout_i,
  input  logic             clr_cnt_i,
  input  logic             clr_time_i,
  output logic             cnt_flag_o,
  output logic             time_flag_o
);
  logic set_cnt, set_time, cf_q, tf_q;

  assign set_cnt  = count_i >= level_i;
  assign set_time = (timeout_i != '0) && (count_i != '0) && (timer_i >= timeout_i);

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cf_q <= 1'b0;
      tf_q <= 1'b0;
    end else begin
      cf_q <= (cf_q & ~clr_cnt_i)  | set_cnt;
      tf_q <= (tf_q & ~clr_time_i) | set_time;
    end
  end

  assign cnt_flag_o  = cf_q;
  assign time_flag_o = tf_q;
endmodule

// File: rtl/evt_coalesce.sv
module evt_coalesce
  import evt_coal_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int BYTES_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic [CNT_W/8-1:0] wr_be_i,
  input  logic               evt_valid_i,
  input  logic [BYTES_W-1:0] evt_bytes_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               sum_count_o,
  output logic               sum_time_o,
  output logic               irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] level_q, timeout_q, timer_q, ack_val, cnt;
  logic             ack_fire, clr_cnt, clr_time, cf, tf;

  coal_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .wr_be_i,
    .ctrl_o(ctrl_q), .level_o(level_q), .timeout_o(timeout_q),
    .ack_fire_o(ack_fire), .ack_val_o(ack_val),
    .clr_cnt_o(clr_cnt), .clr_time_o(clr_time)
  );

  coal_counter #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_cnt (
    .clk_i, .rst_ni, .evt_valid_i, .evt_bytes_i,
    .byte_mode_i(ctrl_q.byte_mode), .ack_fire_i(ack_fire),
    .ack_val_i(ack_val), .count_o(cnt)
  );

  coal_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .count_nz_i(cnt != '0), .timer_o(timer_q)
  );

  coal_flags #(.CNT_W(CNT_W)) u_flags (
    .clk_i, .rst_ni, .count_i(cnt), .level_i(level_q), .timer_i(timer_q),
    .timeout_i(timeout_q), .clr_cnt_i(clr_cnt), .clr_time_i(clr_time),
    .cnt_flag_o(cf), .time_flag_o(tf)
  );

  assign count_o     = cnt;
  assign sum_count_o = cf;
  assign sum_time_o  = tf;
  assign irq_o       = (cf & ctrl_q.en_count) | (tf & ctrl_q.en_time);
endmodule

// File: rtl/evt_coalesce_chk.sv
module evt_coalesce_chk
  import evt_coal_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int BYTES_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [CNT_W-1:0]   wr_data_i,
  input logic [CNT_W/8-1:0] wr_be_i,
  input logic               evt_valid_i,
  input logic [BYTES_W-1:0] evt_bytes_i,
  input logic [CNT_W-1:0]   count_o,
  input logic               sum_count_o,
  input logic               sum_time_o,
  input logic               irq_o,
  input ctrl_t              ctrl_q,
  input logic [CNT_W-1:0]   level_q,
  input logic [CNT_W-1:0]   timeout_q,
  input logic [CNT_W-1:0]   timer_q
);
  localparam logic [CNT_W:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};

  logic ack_w, ack_nobe, clr_c, clr_t;
  assign ack_w    = wr_en_i && wr_addr_i == REG_ACK && wr_be_i[0];
  assign ack_nobe = wr_en_i && wr_addr_i == REG_ACK && !wr_be_i[0];
  assign clr_c    = wr_en_i && wr_addr_i == REG_STATUS && wr_be_i[0] && wr_data_i[0];
  assign clr_t    = wr_en_i && wr_addr_i == REG_STATUS && wr_be_i[0] && wr_data_i[1];

  p_unit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && !ctrl_q.byte_mode && !ack_w && count_o != '1)
      |=> count_o == $past(count_o) + 1'b1);

  p_byte_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && ctrl_q.byte_mode && !ack_w &&
     ({1'b0, count_o} + (CNT_W+1)'(evt_bytes_i)) <= MAX_EXT)
      |=> count_o == $past(count_o) + CNT_W'($past(evt_bytes_i)));

  p_ack_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_nobe && !evt_valid_i) |=> $stable(count_o));

  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && !evt_valid_i && wr_data_i >= count_o) |=> count_o == '0);

  p_level_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o >= level_q) |=> sum_count_o);

  p_timer_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |=> timer_q == '0);

  p_timeout_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_q == '0 && !sum_time_o) |=> !sum_time_o);

  p_sticky_cnt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_count_o && !clr_c) |=> sum_count_o);

  p_sticky_time_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_time_o && !clr_t) |=> sum_time_o);

  p_irq_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sum_count_o || sum_time_o));
endmodule

bind evt_coalesce evt_coalesce_chk #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .wr_be_i(wr_be_i), .evt_valid_i(evt_valid_i),
  .evt_bytes_i(evt_bytes_i), .count_o(count_o), .sum_count_o(sum_count_o),
  .sum_time_o(sum_time_o), .irq_o(irq_o), .ctrl_q(ctrl_q), .level_q(level_q),
  .timeout_q(timeout_q), .timer_q(timer_q)
);

// File: tb/evt_coalesce_bench.sv
module evt_coalesce_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        evt_valid = 1'b0;
  logic [15:0] evt_bytes = '0;
  logic [31:0] count;
  logic        sum_c, sum_t, irq;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_coalesce u_evt_coalesce (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_be_i(wr_be), .evt_valid_i(evt_valid),
    .evt_bytes_i(evt_bytes), .count_o(count), .sum_count_o(sum_c),
    .sum_time_o(sum_t), .irq_o(irq)
  );

  // reference state, built from the requirements
  logic [31:0] m_count, m_timer, m_level, m_tout;
  logic [2:0]  m_ctrl;
  logic        m_cf, m_tf;

  function automatic logic [31:0] next_count(logic [31:0] c, logic ev, logic bmode,
                                             logic [15:0] by, logic ack, logic [31:0] val);
    logic [33:0] t, s;
    t = {2'b0, c} + (ev ? (bmode ? {18'b0, by} : 34'd1) : 34'd0);
    s = ack ? {2'b0, val} : 34'd0;
    if (t <= s) return 32'd0;
    if (t - s > 34'h0_FFFF_FFFF) return 32'hFFFF_FFFF;
    return 32'(t - s);
  endfunction

  function automatic logic [31:0] lane_merge(logic [31:0] old, logic [31:0] d, logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_count <= '0; m_timer <= '0; m_level <= '1; m_tout <= '0;
      m_ctrl <= '0; m_cf <= 1'b0; m_tf <= 1'b0;
    end else begin : mdl
      logic ack, clc, clt;
      ack = wr_en && wr_addr == 3'd3 && wr_be[0];
      clc = wr_en && wr_addr == 3'd4 && wr_be[0] && wr_data[0];
      clt = wr_en && wr_addr == 3'd4 && wr_be[0] && wr_data[1];
      m_count <= next_count(m_count, evt_valid, m_ctrl[0], evt_bytes, ack, wr_data);
      m_timer <= (m_count == 0) ? 32'd0 : ((m_timer == '1) ? m_timer : m_timer + 1);
      m_cf <= (m_cf & ~clc) | (m_count >= m_level);
      m_tf <= (m_tf & ~clt) | (m_tout != 0 && m_count != 0 && m_timer >= m_tout);
      if (wr_en && wr_addr == 3'd0 && wr_be[0]) m_ctrl <= wr_data[2:0];
      if (wr_en && wr_addr == 3'd1) m_level <= lane_merge(m_level, wr_data, wr_be);
      if (wr_en && wr_addr == 3'd2) m_tout  <= lane_merge(m_tout, wr_data, wr_be);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R5 count vs model", count, m_count);
      chk("R6 count flag vs model", 32'(sum_c), 32'(m_cf));
      chk("R7 time flag vs model", 32'(sum_t), 32'(m_tf));
      chk("R11 irq vs model", 32'(irq), 32'((m_cf & m_ctrl[1]) | (m_tf & m_ctrl[2])));
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clr_in();
    wr_en = 1'b0; wr_be = '0; wr_data = '0; wr_addr = '0;
    evt_valid = 1'b0; evt_bytes = '0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, logic [3:0] be);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    cyc();
    clr_in();
  endtask

  task automatic ev(logic [15:0] by);
    evt_valid = 1'b1; evt_bytes = by;
    cyc();
    clr_in();
  endtask

  task automatic idle(int n);
    repeat (n) cyc();
  endtask

  initial begin
    #500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 count flag", 32'(sum_c), 0);
    chk("R1 time flag", 32'(sum_t), 0);
    chk("R1 irq", 32'(irq), 0);
    cmp_on = 1'b1;

    ev(16'd9); ev(16'd9); ev(16'd9);
    chk("R2 unit mode count", count, 3);

    wr(3'd3, 32'd2, 4'b1110);
    chk("R4 ack without lane 0", count, 3);
    wr(3'd3, 32'd2, 4'b0001);
    chk("R4 ack applied", count, 1);

    wr(3'd0, 32'h1, 4'b0001);
    ev(16'd100);
    chk("R3 byte mode count", count, 101);

    evt_valid = 1'b1; evt_bytes = 16'd10;
    wr(3'd3, 32'd50, 4'b0001);
    chk("R5 event and ack same cycle", count, 61);
    wr(3'd3, 32'd1000, 4'b0001);
    chk("R5 saturate at zero", count, 0);

    wr(3'd0, 32'h0, 4'b0001);
    wr(3'd1, 32'd5, 4'b0001);
    repeat (6) ev(16'd0);
    idle(1);
    chk("R12 partial lane write of threshold", 32'(sum_c), 0);
    wr(3'd1, 32'd5, 4'b1111);
    idle(1);
    chk("R6 threshold flag", 32'(sum_c), 1);
    chk("R11 irq masked", 32'(irq), 0);
    wr(3'd0, 32'h2, 4'b0001);
    chk("R11 irq enabled", 32'(irq), 1);

    wr(3'd4, 32'h1, 4'b0001);
    chk("R10 set wins over clear", 32'(sum_c), 1);
    wr(3'd3, 32'hFFFF_FFFF, 4'b0001);
    wr(3'd4, 32'h1, 4'b0001);
    chk("R10 clear", 32'(sum_c), 0);
    wr(3'd1, 32'hFFFF_FFFF, 4'b1111);

    wr(3'd2, 32'd4, 4'b1111);
    ev(16'd0);
    idle(4);
    chk("R7 not before T+1 edges", 32'(sum_t), 0);
    idle(1);
    chk("R7 set at T+1 edges", 32'(sum_t), 1);

    wr(3'd3, 32'hFFFF_FFFF, 4'b0001);
    wr(3'd4, 32'h2, 4'b0001);
    chk("R10 time flag clear", 32'(sum_t), 0);
    ev(16'd0);
    idle(2);
    wr(3'd3, 32'd1, 4'b0001);
    ev(16'd0);
    idle(4);
    chk("R8 timer restarted", 32'(sum_t), 0);
    idle(1);
    chk("R8 set after full new period", 32'(sum_t), 1);

    wr(3'd3, 32'hFFFF_FFFF, 4'b0001);
    wr(3'd4, 32'h2, 4'b0001);
    wr(3'd2, 32'd0, 4'b1111);
    ev(16'd0);
    idle(20);
    chk("R9 zero timeout disables", 32'(sum_t), 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op;
      evt_valid = ($urandom_range(0, 1) == 1);
      evt_bytes = 16'($urandom_range(0, 300));
      op = $urandom_range(0, 19);
      wr_en = 1'b1;
      wr_be = 4'($urandom_range(0, 15));
      wr_data = $urandom;
      case (op)
        0, 1, 2, 3: begin wr_addr = 3'd3; wr_data = $urandom_range(0, 400); end
        4:          begin wr_addr = 3'd0; wr_data = $urandom_range(0, 7); end
        5:          begin wr_addr = 3'd1; wr_data = $urandom_range(0, 900); end
        6:          begin wr_addr = 3'd2; wr_data = $urandom_range(0, 30); end
        7, 8:       begin wr_addr = 3'd4; wr_data = $urandom_range(0, 3); end
        default:    wr_en = 1'b0;
      endcase
      cyc();
      clr_in();
    end

    idle(2);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule